// File: doc/BRIEF.md
# Two-Bit-Per-Cycle CRC-8 Generator

This block computes an 8-bit CRC over a message presented two bits per clock, most significant bit first. Each accepted pair of message bits is combined with the top two bits of the running remainder to form an index into a four-entry lookup. The remainder then moves up by two places with zeros filling the bottom, and the selected entry is XORed into it. Message bits never enter the register directly. Because of this, no trailing zeros need to be pushed through after the message, and the remainder is final as soon as the last pair has been absorbed.

A transfer begins with a one-cycle `start` pulse, which clears the remainder to zero. The source then supplies pairs qualified by a valid strobe and marks the final pair with a last flag. One cycle after that pair is accepted, the block raises a one-cycle completion pulse. The remainder output is driven from the register at all times, so it holds the finished CRC during that pulse and afterwards.

Top module: `crc2_engine`

## Requirements
- R1: After reset, `done_o` is low, `crc_o` is 0x00, and the engine is idle.
- R2: A cycle with `start_i` high sets `crc_o` to 0x00 in the next cycle and makes the engine busy.
- R3: For each accepted pair `d` (bit 1 sent first), the index is `crc[7:6] ^ d`, and the next remainder is `(crc << 2) ^ T[index]` with T[0]=0x00, T[1]=0x95, T[2]=0xBF, T[3]=0x2A. These entries are derived from the polynomial low byte 0x95.
- R4: While busy, a cycle with `in_valid_i` low leaves `crc_o` unchanged.
- R5: `done_o` is high in the cycle after a pair with `in_last_i` high is accepted, and `crc_o` then holds the final remainder.
- R6: `done_o` lasts exactly one cycle. After it, the engine is idle: pairs offered without a new start leave `crc_o` unchanged and produce no `done_o`.
- R7: The final remainder equals the remainder of the message times x^8 divided by x^8+0x95. This is the value that a bit-serial divider gives when eight zero bits are appended to the message.
- R8: A start while busy discards the transfer in progress and begins a new one from 0x00.
- R9: A pair offered in the same cycle as `start_i` is not absorbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clears the remainder and opens a transfer |
| in_valid_i | input | 1 | Qualifies `in_data_i` |
| in_data_i | input | 2 | Message pair, bit 1 earlier in the message |
| in_last_i | input | 1 | Marks the final pair of the transfer |
| done_o | output | 1 | One-cycle pulse after the last pair is absorbed |
| crc_o | output | 8 | Current remainder; final value when `done_o` is high |

## Verification
On every cycle, assertions check these rules: clearing on start, holding the remainder through gaps and while idle, the completion pulse following an accepted last pair, and that pulse ending after one cycle. They cannot show that the lookup entries and the shift produce the correct remainder. The bench shows this by following each cycle with a bit-serial model. It also compares each finished transfer with a separate long division that appends zeros to the message. Restarts in mid-transfer, a start that collides with data, and data offered while idle are exercised only as bench scenarios.

// File: rtl/crc2_pkg.sv
package crc2_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   done;
    } ctrl_s;

endpackage

// File: rtl/crc2_table.sv
module crc2_table #(
    parameter int               CRC_W = 8,
    parameter int               SYM_W = 2,
    parameter logic [CRC_W-1:0] POLY  = 8'h95
) (
    output logic [(2**SYM_W)*CRC_W-1:0] entry_o
);
    localparam int N_ENT = 2**SYM_W;

    // Entry for an index: the remainder left after SYM_W serial steps on a
    // register whose top bits hold the index and whose input bits are zero.
    function automatic logic [CRC_W-1:0] fold(input int unsigned idx);
        logic [CRC_W-1:0] r;
        r = CRC_W'(idx) << (CRC_W - SYM_W);
        for (int k = 0; k < SYM_W; k++) begin
            if (r[CRC_W-1]) r = (r << 1) ^ POLY;
            else            r = r << 1;
        end
        return r;
    endfunction

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        assign entry_o[g*CRC_W +: CRC_W] = fold(g);
    end

endmodule

// File: rtl/crc2_step.sv
module crc2_step #(
    parameter int CRC_W = 8,
    parameter int SYM_W = 2
) (
    input  logic [CRC_W-1:0]             crc_i,
    input  logic [SYM_W-1:0]             sym_i,
    input  logic [(2**SYM_W)*CRC_W-1:0]  table_i,
    output logic [CRC_W-1:0]             crc_o
);
    logic [SYM_W-1:0] idx;

    always_comb begin
        idx   = crc_i[CRC_W-1 -: SYM_W] ^ sym_i;
        crc_o = (crc_i << SYM_W) ^ table_i[idx*CRC_W +: CRC_W];
    end

endmodule

// File: rtl/crc2_ctrl.sv
module crc2_ctrl
    import crc2_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic valid_i,
    input  logic last_i,
    output logic clear_o,
    output logic absorb_o,
    output logic busy_o,
    output logic done_o
);
    ctrl_s st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.done = 1'b0;
        clear_o  = start_i;
        absorb_o = 1'b0;
        if (start_i) begin
            st_d.phase = PH_RUN;
        end else if (st_q.phase == PH_RUN && valid_i) begin
            absorb_o = 1'b1;
            if (last_i) begin
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = (st_q.phase == PH_RUN);
    assign done_o = st_q.done;

    p_done_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && valid_i && last_i && !start_i) |=> done_o);

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

endmodule

// File: rtl/crc2_engine.sv
module crc2_engine #(
    parameter int               CRC_W = 8,
    parameter int               SYM_W = 2,
    parameter logic [CRC_W-1:0] POLY  = 8'h95
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             in_valid_i,
    input  logic [SYM_W-1:0] in_data_i,
    input  logic             in_last_i,
    output logic             done_o,
    output logic [CRC_W-1:0] crc_o
);
    localparam int TBL_BITS = (2**SYM_W) * CRC_W;

    logic [TBL_BITS-1:0] tbl;
    logic [CRC_W-1:0]    stepped;
    logic                clear, absorb, busy;
    logic [CRC_W-1:0]    crc_d, crc_q;

    crc2_table #(.CRC_W(CRC_W), .SYM_W(SYM_W), .POLY(POLY)) u_table (
        .entry_o (tbl)
    );

    crc2_step #(.CRC_W(CRC_W), .SYM_W(SYM_W)) u_step (
        .crc_i   (crc_q),
        .sym_i   (in_data_i),
        .table_i (tbl),
        .crc_o   (stepped)
    );

    crc2_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .valid_i  (in_valid_i),
        .last_i   (in_last_i),
        .clear_o  (clear),
        .absorb_o (absorb),
        .busy_o   (busy),
        .done_o   (done_o)
    );

    always_comb begin
        crc_d = crc_q;
        if (clear)       crc_d = '0;
        else if (absorb) crc_d = stepped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc_o = crc_q;

    p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (crc_o == '0));

    p_gap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !in_valid_i && !start_i) |=> $stable(crc_o));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_i) |=> $stable(crc_o));

endmodule

// File: tb/sim_crc2_engine.sv
module sim_crc2_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       valid = 1'b0;
    logic [1:0] data  = 2'b00;
    logic       last  = 1'b0;
    logic       done;
    logic [7:0] crc;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    localparam logic [7:0] POLY = 8'h95;

    always #10 clk = ~clk;

    crc2_engine u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .in_valid_i (valid),
        .in_data_i  (data),
        .in_last_i  (last),
        .done_o     (done),
        .crc_o      (crc)
    );

    // Behavioural model: bit-serial division, one bit at a time
    logic [7:0] m_crc  = 8'h00;
    bit         m_busy = 0;
    bit         m_done = 0;

    function automatic logic [7:0] serial_bit(input logic [7:0] r, input logic b);
        logic fb;
        fb = r[7] ^ b;
        r  = r << 1;
        if (fb) r = r ^ POLY;
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_crc = 8'h00; m_busy = 0; m_done = 0;
        end else if (start) begin
            m_crc = 8'h00; m_busy = 1; m_done = 0;
        end else if (m_busy && valid) begin
            m_crc  = serial_bit(serial_bit(m_crc, data[1]), data[0]);
            m_done = last;
            m_busy = !last;
        end else begin
            m_done = 0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Every-cycle comparison (R3 remainder, R5 pulse)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R3 per-cycle remainder", crc, m_crc);
            check("R5 per-cycle done", done, m_done);
        end
    end

    // Independent augmented long division (message then eight zeros)
    function automatic logic [7:0] aug_crc(input bit q[$]);
        logic [7:0] r;
        logic       top;
        r = 8'h00;
        for (int i = 0; i < q.size() + 8; i++) begin
            top = r[7];
            r   = {r[6:0], (i < q.size()) ? q[i] : 1'b0};
            if (top) r = r ^ POLY;
        end
        return r;
    endfunction

    task automatic put(input logic s, input logic v, input logic [1:0] d, input logic l);
        @(negedge clk);
        start = s; valid = v; data = d; last = l;
    endtask

    task automatic idle();
        put(1'b0, 1'b0, 2'b00, 1'b0);
    endtask

    task automatic run_msg(input bit q[$], input bit gaps, input string tag);
        logic [7:0] exp;
        exp = aug_crc(q);
        put(1'b1, 1'b0, 2'b00, 1'b0);
        for (int i = 0; i < q.size(); i += 2) begin
            if (gaps && (i % 4 == 2)) begin
                logic [7:0] held;
                idle();
                held = crc;
                @(negedge clk);
                check("R4 gap hold", crc, held);
            end
            put(1'b0, 1'b1, {q[i], q[i+1]}, (i + 2 >= q.size()));
        end
        @(negedge clk);
        check({"R5 done after last ", tag}, done, 1);
        check({"R7 final remainder ", tag}, crc, exp);
        start = 0; valid = 0; last = 0;
        @(negedge clk);
        check("R6 done one cycle", done, 0);
    endtask

    function automatic void push_byte(ref bit q[$], input logic [7:0] b);
        for (int k = 7; k >= 0; k--) q.push_back(b[k]);
    endfunction

    initial begin
        bit q[$];
        logic [7:0] held;
        repeat (3) @(negedge clk);
        check("R1 reset crc", crc, 0);
        check("R1 reset done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", crc, 0);

        // R3 table entries: single-pair messages from a zero remainder
        for (int d = 0; d < 4; d++) begin
            logic [7:0] t[4] = '{8'h00, 8'h95, 8'hBF, 8'h2A};
            put(1'b1, 1'b0, 2'b00, 1'b0);
            put(1'b0, 1'b1, 2'(d), 1'b1);
            @(negedge clk);
            check("R3 table entry", crc, t[d]);
            idle();
        end

        q.delete(); push_byte(q, 8'hA7); push_byte(q, 8'h3C);
        run_msg(q, 0, "two bytes");
        q.delete(); push_byte(q, 8'hFF); push_byte(q, 8'hFF); push_byte(q, 8'hFF);
        run_msg(q, 1, "all ones gapped");
        q.delete(); push_byte(q, 8'h00); push_byte(q, 8'h00);
        run_msg(q, 0, "all zeros");
        q.delete(); q.push_back(1'b1); q.push_back(1'b0);
        run_msg(q, 0, "single pair");
        q.delete();
        for (int n = 0; n < 24; n++) push_byte(q, 8'($urandom));
        run_msg(q, 1, "random long");

        // R6: data offered while idle is ignored
        held = crc;
        put(1'b0, 1'b1, 2'b11, 1'b0);
        put(1'b0, 1'b1, 2'b01, 1'b1);
        idle();
        check("R6 idle data ignored", crc, held);
        check("R6 idle no done", done, 0);

        // R9: pair with start is not absorbed
        put(1'b1, 1'b1, 2'b11, 1'b0);
        idle();
        check("R9 start wins over data", crc, 0);

        // R8: restart in mid-transfer
        put(1'b0, 1'b1, 2'b10, 1'b0);
        put(1'b0, 1'b1, 2'b01, 1'b0);
        idle();
        check("R8 partial nonzero", (crc != 0), 1);
        q.delete(); push_byte(q, 8'h5E);
        run_msg(q, 0, "after restart R8");

        // R2: start clears a nonzero remainder
        check("R2 precondition", (crc != 0), 1);
        put(1'b1, 1'b0, 2'b00, 1'b0);
        idle();
        check("R2 start clears", crc, 0);

        repeat (2) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule